// File: doc/BRIEF.md
# Two-Wire Register-Space Slave

This block is the slave end of a two-wire serial bus (clock line and bidirectional data line). It gives a bus master byte access to a 64-entry register space through a 6-bit word pointer. The clock and data lines are sampled in the system clock domain through two-flop synchronizers. The data line is driven only by an open-drain pull-low enable. On the other side, the block drives a simple single-cycle memory port: a write strobe, an address equal to the pointer, write data, and read data that the attached register file must return combinationally.

A write transaction carries the 7-bit device address 68h with a direction bit of 0 (byte D0h). The first byte after it loads the pointer. Each further byte is written at the pointer, and the pointer then steps forward. A read transaction (byte D1h) returns bytes starting at the pointer, most significant bit first. The pointer moves forward only when the master acknowledges a byte. A read that is not preceded by a pointer write continues from wherever the last transaction left the pointer. A power-fail input overrides everything: it drops the transfer, clears the pointer and makes the block deaf to the bus while it is high.

The controller states are ST_IDLE, ST_DEVADR (shift in the address byte), ST_DEVACK, ST_WORD (shift in the pointer byte), ST_WORDACK, ST_WDATA, ST_WACK, ST_RLOAD (one-cycle fetch from the register file), ST_RDATA (shift a byte out) and ST_RACK (sample the master's acknowledge).

The transitions are as follows:
- Power-fail takes any state to ST_IDLE.
- START takes any state to ST_DEVADR.
- STOP takes any state to ST_IDLE.
- ST_DEVADR goes to ST_DEVACK on a match, or to ST_IDLE on a mismatch, at the falling clock edge after the eighth bit.
- ST_DEVACK goes to ST_WORD (write) or ST_RLOAD (read).
- ST_WORD goes to ST_WORDACK, and ST_WORDACK goes to ST_WDATA.
- ST_WDATA goes to ST_WACK, and ST_WACK goes back to ST_WDATA.
- ST_RLOAD goes to ST_RDATA, and ST_RDATA goes to ST_RACK.
- ST_RACK goes to ST_RLOAD if the master acknowledged, or to ST_IDLE if it did not.

Top module: `tws_regslave`

## Requirements
- R1: After reset the data line is released, no write strobe is issued and the pointer is 0, so a read straight after reset returns entry 0.
- R2: A START is the data line falling while the clock line is high, and a STOP is the data line rising while the clock is high. A START seen in mid-transaction (repeated START) restarts address matching without a STOP.
- R3: Only an address byte whose upper seven bits equal 68h is acknowledged; bit 0 of that byte is the direction (0 write, 1 read). After any other address byte the block stays silent and ignores the rest of the transaction, writing nothing.
- R4: In a write, the byte after the address byte loads the pointer (its upper two bits are ignored). The block acknowledges the address byte, the pointer byte and every data byte by holding the data line low through the high phase of the ninth clock.
- R5: Each data byte of a write is stored at the pointer with one write strobe, after which the pointer increments; any number of bytes may follow one pointer byte.
- R6: The pointer is 6 bits wide and steps from 63 to 0, both when writing and when reading.
- R7: In a read, the byte at the pointer is sent MSB first, the data line changes only while the clock line is low, and the pointer increments only when the master acknowledges (data low on the ninth clock).
- R8: When the master does not acknowledge, the block releases the data line and leaves the pointer unchanged, so the next current-position read returns the same byte.
- R9: A read that is not preceded by a pointer write starts at the pointer value left by the previous transaction.
- R10: While power-fail is high, any transfer is dropped, the pointer is set to 0, the data line is released, nothing is acknowledged and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull | output | 1 | Open-drain enable: 1 pulls the data line low |
| pwr_fail | input | 1 | Supply out of tolerance: abort and ignore the bus |
| mem_we | output | 1 | One-cycle write strobe to the register file |
| mem_addr | output | 6 | Register file address (the pointer) |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Combinational read data at mem_addr |

## Verification
A wrong pointer shows up at the latest on the next read: the master gets a byte from the wrong entry within nine bus clocks of the address acknowledge. A pointer that moves on a not-acknowledge or fails to wrap shows up in the following current-position read. A state machine that leaves an acknowledge state at the wrong edge either misses the ninth-clock low on the data line or corrupts the next bit sampled, which is visible in the same byte. A power-fail that is not honoured shows up as an acknowledge to an address sent while it is high, or as a read after it that does not start at entry 0.

// File: rtl/tws_pkg.sv
package tws_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_WORD,
        ST_WORDACK,
        ST_WDATA,
        ST_WACK,
        ST_RLOAD,
        ST_RDATA,
        ST_RACK
    } tws_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } tws_bus_ev_t;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tws_cond.sv
module tws_cond
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_raw,
    input  logic        sda_raw,
    output tws_bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             scl_q, sda_q;

    assign raw = {scl_raw, sda_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        tws_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw[g]),
            .q    (synced[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= synced[1];
            sda_q <= synced[0];
        end
    end

    always_comb begin
        ev.sda   = synced[0];
        ev.rise  = synced[1] & ~scl_q;
        ev.fall  = ~synced[1] & scl_q;
        ev.start = synced[1] & scl_q & sda_q & ~synced[0];
        ev.stop  = synced[1] & scl_q & ~sda_q & synced[0];
    end
endmodule

// File: rtl/tws_fsm.sv
module tws_fsm
    import tws_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-2:0] DEV_ADDR = 7'h68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tws_bus_ev_t       ev,
    input  logic              pwr_fail,
    output logic              sda_pull,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int              CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    tws_state_e        state, nstate;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic [ADDR_W-1:0] ptr;
    logic              rw, mack, wr_pulse;
    logic              byte_done;

    assign byte_done = ev.fall && (bitcnt == FULL);

    // next-state logic
    always_comb begin
        nstate = state;
        if (pwr_fail)      nstate = ST_IDLE;
        else if (ev.start) nstate = ST_DEVADR;
        else if (ev.stop)  nstate = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:    ;
                ST_DEVADR:  if (byte_done)
                                nstate = (shreg[DATA_W-1:1] == DEV_ADDR) ? ST_DEVACK : ST_IDLE;
                ST_DEVACK:  if (ev.fall) nstate = rw ? ST_RLOAD : ST_WORD;
                ST_WORD:    if (byte_done) nstate = ST_WORDACK;
                ST_WORDACK: if (ev.fall) nstate = ST_WDATA;
                ST_WDATA:   if (byte_done) nstate = ST_WACK;
                ST_WACK:    if (ev.fall) nstate = ST_WDATA;
                ST_RLOAD:   nstate = ST_RDATA;
                ST_RDATA:   if (ev.fall && bitcnt == LAST) nstate = ST_RACK;
                ST_RACK:    if (ev.fall) nstate = mack ? ST_RLOAD : ST_IDLE;
                default:    nstate = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // datapath: shifter, bit counter, pointer, strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bitcnt   <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            mack     <= 1'b0;
            wr_pulse <= 1'b0;
        end else if (pwr_fail) begin
            bitcnt   <= '0;
            ptr      <= '0;
            wr_pulse <= 1'b0;
        end else begin
            wr_pulse <= 1'b0;
            if (ev.start) begin
                bitcnt <= '0;
            end else begin
                case (state)
                    ST_DEVADR, ST_WORD, ST_WDATA: begin
                        if (ev.rise && bitcnt != FULL) begin
                            shreg  <= {shreg[DATA_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (byte_done) begin
                            bitcnt <= '0;
                            if (state == ST_DEVADR) rw <= shreg[0];
                            if (state == ST_WORD)   ptr <= shreg[ADDR_W-1:0];
                            if (state == ST_WDATA)  wr_pulse <= 1'b1;
                        end
                    end
                    ST_RLOAD: begin
                        shreg  <= mem_rdata;
                        bitcnt <= '0;
                    end
                    ST_RDATA: begin
                        if (ev.fall) begin
                            shreg  <= {shreg[DATA_W-2:0], 1'b1};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) mack <= ~ev.sda;
                        if (ev.fall && mack) ptr <= ptr + 1'b1;
                    end
                    default: ;
                endcase
            end
            if (wr_pulse) ptr <= ptr + 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_DEVACK, ST_WORDACK, ST_WACK: sda_pull = 1'b1;
            ST_RDATA:                       sda_pull = ~shreg[DATA_W-1];
            default:                        sda_pull = 1'b0;
        endcase
        if (pwr_fail) sda_pull = 1'b0;
        mem_we    = wr_pulse;
        mem_addr  = ptr;
        mem_wdata = shreg;
    end

    AST_WE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> state == ST_WACK); // R5
    AST_WE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !pwr_fail) |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R5
    AST_PF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (ptr == '0 && state == ST_IDLE)); // R10
    AST_PF_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && $past(pwr_fail)) |-> !mem_we); // R10
    AST_ACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && ev.fall && mack && !pwr_fail && !ev.start && !ev.stop)
        |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R7
    AST_NACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && ev.fall && !mack && !pwr_fail) |=> $stable(ptr)); // R8
endmodule

// File: rtl/tws_regslave.sv
module tws_regslave
    import tws_pkg::*;
#(
    parameter int                ADDR_W      = 6,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-2:0] DEV_ADDR    = 7'h68
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              pwr_fail,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    tws_bus_ev_t ev;

    tws_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_raw(scl_in),
        .sda_raw(sda_in),
        .ev     (ev)
    );

    tws_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .pwr_fail (pwr_fail),
        .sda_pull (sda_pull),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );
endmodule

// File: tb/sim_tws_regslave.sv
module sim_tws_regslave;
    localparam int Q = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, m_scl, m_sda, pwr_fail;
    logic       sda_pull, mem_we;
    logic [5:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    wire        sda_line = m_sda & ~sda_pull;

    logic [7:0] rf    [64];
    logic [7:0] model [64];

    tws_regslave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_pull(sda_pull), .pwr_fail(pwr_fail), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] seed(int i);
        return 8'(i * 37 + 11);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) rf[i] <= seed(i);
        end else if (mem_we) begin
            rf[mem_addr] <= mem_wdata;
        end
    end
    assign mem_rdata = rf[mem_addr];

    int n_cmp = 0, n_bad = 0;
    int sda_viol = 0, we_in_pf = 0;

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard
    logic [7:0] exp_q[$];
    logic [7:0] obs_q[$];
    string      tag_q[$];

    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] a, e;
                string t;
                a = obs_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(a == e, t, a, e);
            end
        end
    end

    // R7: data line held by the slave must not change while SCL stays high
    logic pull_q, scl_q, pf_q;
    initial begin
        pull_q = 1'b0; scl_q = 1'b1; pf_q = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && !pwr_fail && !pf_q && m_scl && scl_q && sda_pull != pull_q)
                sda_viol++;
            if (pwr_fail && pf_q && mem_we) we_in_pf++;
            pull_q = sda_pull; scl_q = m_scl; pf_q = pwr_fail;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        idle(Q); m_sda = 1'b1; idle(Q); m_scl = 1'b1;
        idle(Q); m_sda = 1'b0; idle(Q); m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        idle(Q); m_sda = 1'b0; idle(Q); m_scl = 1'b1;
        idle(Q); m_sda = 1'b1; idle(Q);
    endtask

    task automatic clk_bit(input bit b, output bit s);
        idle(Q); m_sda = b; idle(Q); m_scl = 1'b1;
        idle(Q); s = sda_line; idle(Q); m_scl = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic wr_ack(input logic [7:0] v, input string req);
        bit a;
        wr_byte(v, a);
        check(a, req, a, 1);
    endtask

    task automatic rd_byte(input logic [7:0] expv, input bit mack, input string tag);
        bit s;
        logic [7:0] v;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        v = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            v = {v[6:0], s};
        end
        clk_bit(!mack, s);
        obs_q.push_back(v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit a;
        bit s;
        m_scl = 1'b1; m_sda = 1'b1; pwr_fail = 1'b0; rst_n = 1'b0;
        for (int i = 0; i < 64; i++) model[i] = seed(i);
        idle(5);
        rst_n = 1'b1;
        idle(4);

        // R1 reset state
        check(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);
        check(mem_we == 1'b0, "R1 no write", mem_we, 0);
        bus_start(); wr_ack(8'hD1, "R3 read address");
        rd_byte(model[0], 1'b0, "R1 pointer zero"); bus_stop();

        // R3 foreign addresses are ignored
        bus_start(); wr_byte(8'hA0, a); check(!a, "R3 foreign addr", a, 0);
        wr_byte(8'd20, a); wr_byte(8'hFF, a); check(!a, "R3 silent", a, 0);
        bus_stop();
        bus_start(); wr_byte(8'hD2, a); check(!a, "R3 near addr", a, 0); bus_stop();

        // R4/R5 write burst
        bus_start(); wr_ack(8'hD0, "R4 addr ack"); wr_ack(8'd5, "R4 word ack");
        wr_ack(8'h11, "R5 data"); wr_ack(8'h22, "R5 data"); wr_ack(8'h33, "R5 data");
        bus_stop();
        model[5] = 8'h11; model[6] = 8'h22; model[7] = 8'h33;

        // R2/R7 random read through repeated START
        bus_start(); wr_ack(8'hD0, "R2"); wr_ack(8'd5, "R2");
        bus_start(); wr_ack(8'hD1, "R2 repeated start");
        rd_byte(8'h11, 1'b1, "R7 byte0"); rd_byte(8'h22, 1'b1, "R7 byte1");
        rd_byte(8'h33, 1'b0, "R8 last byte"); bus_stop();

        // R8/R9 current position read
        bus_start(); wr_ack(8'hD1, "R9");
        rd_byte(model[7], 1'b0, "R8 pointer held on nack"); bus_stop();

        // R3 ignored write left entry 20 intact
        bus_start(); wr_ack(8'hD0, "R3"); wr_ack(8'd20, "R3");
        bus_start(); wr_ack(8'hD1, "R3");
        rd_byte(model[20], 1'b0, "R3 entry untouched"); bus_stop();

        // R6 wrap on write and read
        bus_start(); wr_ack(8'hD0, "R6"); wr_ack(8'd62, "R6");
        wr_ack(8'hAA, "R6"); wr_ack(8'hBB, "R6"); wr_ack(8'hCC, "R6 wrap write");
        bus_stop();
        model[62] = 8'hAA; model[63] = 8'hBB; model[0] = 8'hCC;
        bus_start(); wr_ack(8'hD1, "R9");
        rd_byte(model[1], 1'b0, "R6 R9 pointer after wrap"); bus_stop();
        bus_start(); wr_ack(8'hD0, "R6"); wr_ack(8'd63, "R6");
        bus_start(); wr_ack(8'hD1, "R6");
        rd_byte(8'hBB, 1'b1, "R6"); rd_byte(8'hCC, 1'b1, "R6 read wrap");
        rd_byte(model[1], 1'b0, "R6"); bus_stop();

        // R10 power fail
        bus_start(); wr_ack(8'hD0, "R10"); wr_ack(8'd40, "R10");
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        pwr_fail = 1'b1;
        idle(4);
        check(sda_pull == 1'b0, "R10 released", sda_pull, 0);
        bus_start(); wr_byte(8'hD0, a); check(!a, "R10 deaf", a, 0);
        wr_byte(8'd40, a); wr_byte(8'h77, a);
        bus_stop();
        pwr_fail = 1'b0;
        idle(2 * Q);
        bus_start(); wr_ack(8'hD1, "R10");
        rd_byte(model[0], 1'b0, "R10 pointer cleared"); bus_stop();
        bus_start(); wr_ack(8'hD0, "R10"); wr_ack(8'd40, "R10");
        bus_start(); wr_ack(8'hD1, "R10");
        rd_byte(model[40], 1'b0, "R10 no write"); bus_stop();

        idle(4 * Q);
        check(sda_viol == 0, "R7 sda stable while scl high", sda_viol, 0);
        check(we_in_pf == 0, "R10 strobe during power fail", we_in_pf, 0);
        check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule